// File: doc/BRIEF.md
# Sticky Error Status Register with Masks

This block holds a 64-bit error status word for an on-chip bus interface unit. Four hardware conditions each latch a sticky flag:
- either of two PLL lock inputs seen high while power-on reset is low,
- a read or write request longer than one data beat,
- a request of a kind the unit does not accept.

Each flag has its own mask bit. A masked flag still records the event, but it does not drive the error outputs. Software reads the word through a select/read-data path. It clears flags by writing ones to them, and it sets masks with ordinary writes.

Two outputs report errors. A level error line stays high while any unmasked flag is set. A one-cycle exception pulse marks a request that has an unmasked size or kind error and expects a response. A request that expects no response still sets its flag and raises the level line, but gives no pulse.

Top module: `err_status_reg`

## Requirements
- R1: After reset, every flag and mask is 0, `async_err_o` is 0 and `resp_exc_o` is 0.
- R2: The read word has these fields:
  - system-PLL flag at bit 35, dot-PLL flag at bit 34, size flag at bit 33, kind flag at bit 32;
  - the masks for those flags at bits 3, 2, 1 and 0;
  - every other bit reads 0, and `reg_rdata` is 0 while `reg_sel` is low.
- R3: A PLL flag sets on a clock edge where its lock input is 1 and `por_i` is 0. A lock input seen while `por_i` is 1 sets nothing.
- R4: The size flag sets on a valid request of kind READ (1) or WRITE (2) whose size code is 1 (16 bytes) or 2 (32 bytes). Size codes 0 (one beat) and 3 set nothing, and other kinds are not size-checked.
- R5: The kind flag sets on a valid request whose kind code is one of the following: 0 (null), 3 (exclusive start), 4 (snoop), 5 (peek write) or 6 (debug). Kind codes 1, 2 and 7 set nothing.
- R6: Flags are sticky. A write with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. Writes to reserved bits have no effect.
- R7: When a set event and a write-one clear hit the same flag on the same edge, the flag ends at 1.
- R8: Mask bits read back as written. A set mask keeps its flag out of both outputs, but the flag still latches.
- R9: `async_err_o` changes on the same edge as the flags and masks. It equals the OR over all flags of (flag AND NOT mask), and holds until the flags are cleared or masked.
- R10: `resp_exc_o` is high for one cycle, on the edge that captures a valid request with `req_resp_i`=1 and an unmasked size or kind error. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe, valid with reg_sel |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data |
| sys_lock_i | input | 1 | System PLL lock level |
| dot_lock_i | input | 1 | Dot-clock PLL lock level |
| por_i | input | 1 | Power-on reset level |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 3 | Request kind code |
| req_size_i | input | 2 | Request size code |
| req_resp_i | input | 1 | Request expects a response |
| async_err_o | output | 1 | Level error output |
| resp_exc_o | output | 1 | Exception pulse for the response |

## Verification
Every one of the eight kind codes is sent so that accepted and rejected kinds are told apart. Size codes are crossed with READ, WRITE and a non-data kind, which separates an oversize error from a kind error. Each error request is sent both with and without a response expected; this tells the exception path apart from the level error line. Further writes combine clear bits with a set event on the same edge, and masks are applied before and after a flag is set. These show that a mask gates only the outputs and that a set beats a clear.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
   localparam int NUM_ERR  = 4;
   localparam int KIND_W   = 3;
   localparam int SIZE_W   = 2;
   localparam int IDX_KIND = 0;
   localparam int IDX_SIZE = 1;
   localparam int IDX_DOT  = 2;
   localparam int IDX_SYS  = 3;

   typedef enum logic [KIND_W-1:0] {
      K_NULL    = 3'd0,
      K_READ    = 3'd1,
      K_WRITE   = 3'd2,
      K_EXCL    = 3'd3,
      K_SNOOP   = 3'd4,
      K_PEEK_WR = 3'd5,
      K_DEBUG   = 3'd6,
      K_PEEK_RD = 3'd7
   } req_kind_e;

   typedef enum logic [SIZE_W-1:0] {
      S_ONE  = 2'd0,
      S_16B  = 2'd1,
      S_32B  = 2'd2,
      S_RSV  = 2'd3
   } req_size_e;

   function automatic logic kind_rejected(input logic [KIND_W-1:0] k);
      case (req_kind_e'(k))
         K_NULL, K_EXCL, K_SNOOP, K_PEEK_WR, K_DEBUG: return 1'b1;
         default:                                    return 1'b0;
      endcase
   endfunction

   function automatic logic size_oversized(input logic [SIZE_W-1:0] s);
      return (req_size_e'(s) == S_16B) || (req_size_e'(s) == S_32B);
   endfunction
endpackage

// File: rtl/err_event_decode.sv
module err_event_decode
   import err_stat_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sys_lock_i,
   input  logic               dot_lock_i,
   input  logic               por_i,
   input  logic               req_valid_i,
   input  logic [KIND_W-1:0]  req_kind_i,
   input  logic [SIZE_W-1:0]  req_size_i,
   input  logic               req_resp_i,
   input  logic [NUM_ERR-1:0] mask_i,
   output logic [NUM_ERR-1:0] set_o,
   output logic               exc_o
);
   logic is_data_req;
   logic exc_d;
   logic exc_q;

   always_comb begin
      is_data_req = (req_kind_e'(req_kind_i) == K_READ) ||
                    (req_kind_e'(req_kind_i) == K_WRITE);
      set_o           = '0;
      set_o[IDX_SYS]  = sys_lock_i & ~por_i;
      set_o[IDX_DOT]  = dot_lock_i & ~por_i;
      set_o[IDX_SIZE] = req_valid_i & is_data_req & size_oversized(req_size_i);
      set_o[IDX_KIND] = req_valid_i & kind_rejected(req_kind_i);
      exc_d = req_valid_i & req_resp_i &
              ((set_o[IDX_SIZE] & ~mask_i[IDX_SIZE]) |
               (set_o[IDX_KIND] & ~mask_i[IDX_KIND]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) exc_q <= 1'b0;
      else        exc_q <= exc_d;
   end

   assign exc_o = exc_q;

   // R10
   exc_on_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_resp_i && set_o[IDX_KIND] && !mask_i[IDX_KIND]) |=> exc_o);

   // R10
   exc_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid_i || !req_resp_i) |=> !exc_o);
endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
   parameter int NUM = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set_i,
   input  logic [NUM-1:0] clr_i,
   input  logic           mask_we_i,
   input  logic [NUM-1:0] mask_wd_i,
   output logic [NUM-1:0] flag_q_o,
   output logic [NUM-1:0] mask_q_o,
   output logic [NUM-1:0] flag_d_o,
   output logic [NUM-1:0] mask_d_o
);
   if (NUM < 1) begin : g_bad_num
      $error("err_flag_bank: NUM must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_flag
      logic f_q;
      logic f_d;
      logic m_q;
      logic m_d;

      always_comb begin
         f_d = set_i[i] | (f_q & ~clr_i[i]);
         m_d = mask_we_i ? mask_wd_i[i] : m_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'b0;
            m_q <= 1'b0;
         end else begin
            f_q <= f_d;
            m_q <= m_d;
         end
      end

      assign flag_q_o[i] = f_q;
      assign mask_q_o[i] = m_q;
      assign flag_d_o[i] = f_d;
      assign mask_d_o[i] = m_d;

      // R7
      set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q_o[i]);

      // R6
      w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flag_q_o[i]);

      // R6
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> $stable(flag_q_o[i]));
   end
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
   import err_stat_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int FLAG_LSB  = 32,
   parameter int MASK_LSB  = 0,
   parameter bit REG_ASYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sys_lock_i,
   input  logic              dot_lock_i,
   input  logic              por_i,
   input  logic              req_valid_i,
   input  logic [KIND_W-1:0] req_kind_i,
   input  logic [SIZE_W-1:0] req_size_i,
   input  logic              req_resp_i,
   output logic              async_err_o,
   output logic              resp_exc_o
);
   localparam int FLAG_MSB = FLAG_LSB + NUM_ERR - 1;
   localparam int MASK_MSB = MASK_LSB + NUM_ERR - 1;
   localparam logic [DATA_W-1:0] LIVE_BITS =
      ({{(DATA_W-NUM_ERR){1'b0}}, {NUM_ERR{1'b1}}} << FLAG_LSB) |
      ({{(DATA_W-NUM_ERR){1'b0}}, {NUM_ERR{1'b1}}} << MASK_LSB);

   if (FLAG_MSB >= DATA_W || MASK_MSB >= DATA_W) begin : g_bad_width
      $error("err_status_reg: fields exceed DATA_W");
   end
   if (!(MASK_MSB < FLAG_LSB || FLAG_MSB < MASK_LSB)) begin : g_bad_overlap
      $error("err_status_reg: flag and mask fields overlap");
   end

   logic               wr_en;
   logic [NUM_ERR-1:0] set_ev;
   logic [NUM_ERR-1:0] clr_ev;
   logic [NUM_ERR-1:0] flag_q;
   logic [NUM_ERR-1:0] mask_q;
   logic [NUM_ERR-1:0] flag_d;
   logic [NUM_ERR-1:0] mask_d;
   logic               unused_wdata;

   assign wr_en        = reg_sel & reg_wr;
   assign clr_ev       = wr_en ? reg_wdata[FLAG_LSB +: NUM_ERR] : '0;
   assign unused_wdata = ^reg_wdata;

   err_event_decode u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_lock_i  (sys_lock_i),
      .dot_lock_i  (dot_lock_i),
      .por_i       (por_i),
      .req_valid_i (req_valid_i),
      .req_kind_i  (req_kind_i),
      .req_size_i  (req_size_i),
      .req_resp_i  (req_resp_i),
      .mask_i      (mask_q),
      .set_o       (set_ev),
      .exc_o       (resp_exc_o)
   );

   err_flag_bank #(.NUM(NUM_ERR)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_ev),
      .clr_i     (clr_ev),
      .mask_we_i (wr_en),
      .mask_wd_i (reg_wdata[MASK_LSB +: NUM_ERR]),
      .flag_q_o  (flag_q),
      .mask_q_o  (mask_q),
      .flag_d_o  (flag_d),
      .mask_d_o  (mask_d)
   );

   if (REG_ASYNC) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= |(flag_d & ~mask_d);
      end
      assign async_err_o = err_q;
   end else begin : g_err_comb
      logic unused_next;
      assign unused_next = ^{flag_d, mask_d};
      assign async_err_o = |(flag_q & ~mask_q);
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         reg_rdata[FLAG_LSB +: NUM_ERR] = flag_q;
         reg_rdata[MASK_LSB +: NUM_ERR] = mask_q;
      end
   end

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~LIVE_BITS) == '0);

   // R3
   pll_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_lock_i && !por_i) |=> flag_q[IDX_SYS]);

   // R9
   async_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      async_err_o == |(flag_q & ~mask_q));

   // R8
   mask_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[IDX_SIZE] && mask_d[IDX_SIZE]) |=> (flag_q[IDX_SIZE] && mask_q[IDX_SIZE]));
endmodule

// File: tb/test_err_status_reg.sv
module test_err_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        sys_lock_i = 1'b0;
   logic        dot_lock_i = 1'b0;
   logic        por_i = 1'b1;
   logic        req_valid_i = 1'b0;
   logic [2:0]  req_kind_i = 3'd1;
   logic [1:0]  req_size_i = 2'd0;
   logic        req_resp_i = 1'b0;
   logic        async_err_o;
   logic        resp_exc_o;

   int n_checks = 0;
   int n_fails  = 0;

   localparam logic [63:0] B_SYS  = 64'h1 << 35;
   localparam logic [63:0] B_DOT  = 64'h1 << 34;
   localparam logic [63:0] B_SIZE = 64'h1 << 33;
   localparam logic [63:0] B_KIND = 64'h1 << 32;
   localparam logic [63:0] ALL_FLAGS = B_SYS | B_DOT | B_SIZE | B_KIND;

   err_status_reg i_err_status_reg (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sys_lock_i(sys_lock_i), .dot_lock_i(dot_lock_i), .por_i(por_i),
      .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
      .req_size_i(req_size_i), .req_resp_i(req_resp_i),
      .async_err_o(async_err_o), .resp_exc_o(resp_exc_o));

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(output logic [63:0] d);
      reg_sel = 1'b1; reg_wr = 1'b0;
      #1 d = reg_rdata;
      reg_sel = 1'b0;
   endtask

   task automatic wr(input logic [63:0] d);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
      tick();
      reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic send(input logic [2:0] k, input logic [1:0] s, input logic resp);
      req_valid_i = 1'b1; req_kind_i = k; req_size_i = s; req_resp_i = resp;
      tick();
      req_valid_i = 1'b0; req_kind_i = 3'd1; req_size_i = 2'd0; req_resp_i = 1'b0;
   endtask

   task automatic t_reset;
      logic [63:0] d;
      rd(d);
      chk("R1 rdata in reset", d, 64'h0);
      chk("R1 async_err in reset", {63'h0, async_err_o}, 64'h0);
      chk("R1 resp_exc in reset", {63'h0, resp_exc_o}, 64'h0);
      chk("R2 rdata with sel low", reg_rdata, 64'h0);
   endtask

   task automatic t_pll;
      logic [63:0] d;
      sys_lock_i = 1'b1; por_i = 1'b1; tick();
      rd(d); chk("R3 lock during por ignored", d, 64'h0);
      por_i = 1'b0; tick(); sys_lock_i = 1'b0;
      rd(d); chk("R3 sys pll flag", d, B_SYS);
      chk("R9 async after pll flag", {63'h0, async_err_o}, 64'h1);
      dot_lock_i = 1'b1; tick(); dot_lock_i = 1'b0; tick();
      rd(d); chk("R3 dot pll flag sticky", d, B_SYS | B_DOT);
      wr(B_SYS | B_DOT);
      rd(d); chk("R6 pll flags cleared", d, 64'h0);
      chk("R9 async released", {63'h0, async_err_o}, 64'h0);
   endtask

   task automatic t_size;
      logic [63:0] d;
      send(3'd1, 2'd1, 1'b0);
      rd(d); chk("R4 read 16B", d, B_SIZE);
      chk("R10 no exc without resp", {63'h0, resp_exc_o}, 64'h0);
      chk("R9 async without resp", {63'h0, async_err_o}, 64'h1);
      wr(B_SIZE);
      send(3'd2, 2'd2, 1'b0);
      rd(d); chk("R4 write 32B", d, B_SIZE);
      wr(B_SIZE);
      send(3'd1, 2'd0, 1'b0);
      send(3'd2, 2'd3, 1'b0);
      send(3'd7, 2'd2, 1'b0);
      rd(d); chk("R4 one beat, code 3, non-data kind", d, 64'h0);
   endtask

   task automatic t_kind;
      logic [63:0] d;
      logic [7:0] rejected = 8'b0111_1001;
      for (int k = 0; k < 8; k++) begin
         send(3'(k), 2'd0, 1'b0);
         rd(d);
         chk($sformatf("R5 kind %0d", k), d, rejected[k] ? B_KIND : 64'h0);
         wr(ALL_FLAGS);
      end
   endtask

   task automatic t_w1c;
      logic [63:0] d;
      send(3'd2, 2'd1, 1'b0);
      send(3'd4, 2'd0, 1'b0);
      wr(~ALL_FLAGS | B_KIND & ~64'hF);
      wr({28'hFFF_FFFF, 4'b0001, 28'hFFF_FFFF, 4'b0000});
      rd(d); chk("R6 w1c and reserved writes", d, B_SIZE);
      wr(B_SIZE);
      rd(d); chk("R2 reserved read zero", d, 64'h0);
   endtask

   task automatic t_set_wins;
      logic [63:0] d;
      send(3'd0, 2'd0, 1'b0);
      req_valid_i = 1'b1; req_kind_i = 3'd0;
      wr(B_KIND);
      req_valid_i = 1'b0; req_kind_i = 3'd1;
      rd(d); chk("R7 set wins over clear", d, B_KIND);
      wr(B_KIND);
      rd(d); chk("R7 later clear", d, 64'h0);
   endtask

   task automatic t_mask;
      logic [63:0] d;
      wr(64'hA);
      rd(d); chk("R8 mask readback", d, 64'hA);
      wr(64'h1);
      send(3'd0, 2'd0, 1'b1);
      rd(d); chk("R8 masked flag latches", d, B_KIND | 64'h1);
      chk("R8 masked async", {63'h0, async_err_o}, 64'h0);
      chk("R8 masked exc", {63'h0, resp_exc_o}, 64'h0);
      wr(64'h0);
      chk("R9 unmask raises async", {63'h0, async_err_o}, 64'h1);
      wr(B_KIND);
      chk("R9 clear drops async", {63'h0, async_err_o}, 64'h0);
   endtask

   task automatic t_exception;
      send(3'd1, 2'd2, 1'b1);
      chk("R10 size exc pulse", {63'h0, resp_exc_o}, 64'h1);
      tick();
      chk("R10 exc one cycle", {63'h0, resp_exc_o}, 64'h0);
      send(3'd6, 2'd0, 1'b1);
      chk("R10 kind exc pulse", {63'h0, resp_exc_o}, 64'h1);
      wr(ALL_FLAGS);
      send(3'd1, 2'd0, 1'b1);
      chk("R10 good request no exc", {63'h0, resp_exc_o}, 64'h0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1'b1;
            tick();
            t_pll();
            por_i = 1'b1;
            t_size();
            t_kind();
            t_w1c();
            t_set_wins();
            t_mask();
            t_exception();
         end
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule